// File: doc/BRIEF.md
# Last Instruction Context Capture

This block keeps the context an exception handler needs about the most recent floating-point instruction that was not a control instruction. It holds an instruction pointer, an operand pointer and a packed opcode. When a non-control instruction retires, the pipeline drives a retire strobe with the instruction's address and the opcode bytes, and the block captures them. When a control instruction retires, the block keeps its held values.

An initialize or save sequence pulses a clear strobe, which zeroes the whole context. A restore sequence writes saved pointer values through a load port. Each pointer is a segment selector in the upper bits joined to an offset in the lower bits. The opcode register keeps only the three variable bits of the first opcode byte, together with the full second byte.

Top module: `fp_last_ctx`

## Requirements
- R1: After asynchronous reset (rst_ni low), instr_ptr_o, oper_ptr_o and opcode_o are all zero.
- R2: A retire_i pulse with ctrl_i=0 sets instr_ptr_o to {instr_sel_i, instr_off_i} on the next clock edge. The selector occupies bits 47:32 and the offset occupies bits 31:0. The offset given is the address of the first prefix byte.
- R3: A retire_i pulse with ctrl_i=0 sets opcode_o to {op_b0_i[2:0], op_b1_i[7:0]} on the next clock edge. Bits 10:8 come from the first byte and the upper five bits of that byte are discarded.
- R4: A non-control retire with mem_op_i=1 sets oper_ptr_o to {oper_sel_i, oper_off_i}. With mem_op_i=0, the operand pointer value is not defined by this block.
- R5: A retire_i pulse with ctrl_i=1 leaves all three outputs unchanged.
- R6: A clear_i pulse zeroes all three outputs on the next edge, and it takes priority over a retire in the same cycle.
- R7: A load_i pulse sets instr_ptr_o to ld_instr_i and oper_ptr_o to ld_oper_i, and it leaves opcode_o unchanged. clear_i takes priority over load_i, and load_i takes priority over retire_i.
- R8: When no strobe is active, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | Instruction retire strobe |
| ctrl_i | input | 1 | Retiring instruction is a control instruction |
| mem_op_i | input | 1 | Retiring instruction has a memory operand |
| instr_off_i | input | 32 | Instruction offset (first prefix byte) |
| instr_sel_i | input | 16 | Instruction segment selector |
| oper_off_i | input | 32 | Operand offset |
| oper_sel_i | input | 16 | Operand segment selector |
| op_b0_i | input | 8 | First opcode byte after prefixes |
| op_b1_i | input | 8 | Second opcode byte |
| clear_i | input | 1 | Initialize/save clear strobe |
| load_i | input | 1 | Environment restore load strobe |
| ld_instr_i | input | 48 | Restored instruction pointer |
| ld_oper_i | input | 48 | Restored operand pointer |
| instr_ptr_o | output | 48 | Instruction pointer {selector, offset} |
| oper_ptr_o | output | 48 | Operand pointer {selector, offset} |
| opcode_o | output | 11 | Packed last opcode |

## Verification
The bench builds the block with its default widths: a 32-bit offset, a 16-bit selector and a 3-bit first-byte field. At these widths, offsets and selectors with the top bit set exercise the seams between fields in the packed registers. Opcode bytes whose upper five bits vary show that those bits are dropped. Random strobes that overlap in the same cycle reach every branch of the priority order.

// File: rtl/fp_last_ctx_pkg.sv
package fp_last_ctx_pkg;
  parameter int unsigned OFF_W  = 32;
  parameter int unsigned SEL_W  = 16;
  parameter int unsigned B0_W   = 3;
  localparam int unsigned PTR_W = OFF_W + SEL_W;
  localparam int unsigned OPC_W = B0_W + 8;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_CLEAR  = 2'd1,
    ACT_LOAD   = 2'd2,
    ACT_UPDATE = 2'd3
  } ctx_act_e;
endpackage

// File: rtl/fp_ctx_ctrl.sv
module fp_ctx_ctrl
  import fp_last_ctx_pkg::*;
(
  input  logic     retire_i,
  input  logic     ctrl_i,
  input  logic     clear_i,
  input  logic     load_i,
  output ctx_act_e act_o
);
  always_comb begin
    if (clear_i)                 act_o = ACT_CLEAR;
    else if (load_i)             act_o = ACT_LOAD;
    else if (retire_i && !ctrl_i) act_o = ACT_UPDATE;
    else                         act_o = ACT_HOLD;
  end
endmodule

// File: rtl/fp_ctx_reg.sv
module fp_ctx_reg
  import fp_last_ctx_pkg::*;
#(
  parameter int unsigned W = 48,
  parameter bit LOADABLE = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ctx_act_e act_i,
  input  logic     upd_en_i,
  input  logic [W-1:0] upd_val_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] d;

  generate
    if (LOADABLE) begin : g_ld
      always_comb begin
        unique case (act_i)
          ACT_CLEAR:  d = '0;
          ACT_LOAD:   d = ld_val_i;
          ACT_UPDATE: d = upd_en_i ? upd_val_i : q_o;
          default:    d = q_o;
        endcase
      end
    end else begin : g_nold
      logic [W-1:0] unused_ld;
      assign unused_ld = ld_val_i;
      always_comb begin
        unique case (act_i)
          ACT_CLEAR:  d = '0;
          ACT_UPDATE: d = upd_en_i ? upd_val_i : q_o;
          default:    d = q_o;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end
endmodule

// File: rtl/fp_last_ctx.sv
module fp_last_ctx
  import fp_last_ctx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic             ctrl_i,
  input  logic             mem_op_i,
  input  logic [OFF_W-1:0] instr_off_i,
  input  logic [SEL_W-1:0] instr_sel_i,
  input  logic [OFF_W-1:0] oper_off_i,
  input  logic [SEL_W-1:0] oper_sel_i,
  input  logic [7:0]       op_b0_i,
  input  logic [7:0]       op_b1_i,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] ld_instr_i,
  input  logic [PTR_W-1:0] ld_oper_i,
  output logic [PTR_W-1:0] instr_ptr_o,
  output logic [PTR_W-1:0] oper_ptr_o,
  output logic [OPC_W-1:0] opcode_o
);
  ctx_act_e act;
  logic [OPC_W-1:0] opc_packed;
  logic [7:0] unused_b0;

  // constant upper bits of first byte are dropped
  assign opc_packed = {op_b0_i[B0_W-1:0], op_b1_i};
  assign unused_b0  = op_b0_i;

  fp_ctx_ctrl u_ctrl (
    .retire_i(retire_i), .ctrl_i(ctrl_i), .clear_i(clear_i),
    .load_i(load_i), .act_o(act)
  );

  fp_ctx_reg #(.W(PTR_W), .LOADABLE(1'b1)) u_ip (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .upd_en_i(1'b1),
    .upd_val_i({instr_sel_i, instr_off_i}), .ld_val_i(ld_instr_i),
    .q_o(instr_ptr_o)
  );

  fp_ctx_reg #(.W(PTR_W), .LOADABLE(1'b1)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .upd_en_i(mem_op_i),
    .upd_val_i({oper_sel_i, oper_off_i}), .ld_val_i(ld_oper_i),
    .q_o(oper_ptr_o)
  );

  fp_ctx_reg #(.W(OPC_W), .LOADABLE(1'b0)) u_opc (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .upd_en_i(1'b1),
    .upd_val_i(opc_packed), .ld_val_i('0), .q_o(opcode_o)
  );
endmodule

// File: rtl/fp_last_ctx_chk.sv
module fp_last_ctx_chk
  import fp_last_ctx_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             retire_i,
  input logic             ctrl_i,
  input logic             mem_op_i,
  input logic [OFF_W-1:0] instr_off_i,
  input logic [SEL_W-1:0] instr_sel_i,
  input logic [OFF_W-1:0] oper_off_i,
  input logic [SEL_W-1:0] oper_sel_i,
  input logic [7:0]       op_b1_i,
  input logic [7:0]       op_b0_i,
  input logic             clear_i,
  input logic             load_i,
  input logic [PTR_W-1:0] ld_instr_i,
  input logic [PTR_W-1:0] ld_oper_i,
  input logic [PTR_W-1:0] instr_ptr_o,
  input logic [PTR_W-1:0] oper_ptr_o,
  input logic [OPC_W-1:0] opcode_o
);
  logic upd;
  assign upd = retire_i && !ctrl_i && !clear_i && !load_i;

  // R6
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (instr_ptr_o == '0 && oper_ptr_o == '0 && opcode_o == '0));
  // R2
  ip_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> instr_ptr_o == $past({instr_sel_i, instr_off_i}));
  // R3
  opc_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> opcode_o == $past({op_b0_i[B0_W-1:0], op_b1_i}));
  // R4
  dp_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && mem_op_i) |=> oper_ptr_o == $past({oper_sel_i, oper_off_i}));
  // R5
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && ctrl_i && !clear_i && !load_i) |=>
      ($stable(instr_ptr_o) && $stable(oper_ptr_o) && $stable(opcode_o)));
  // R7
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=> (instr_ptr_o == $past(ld_instr_i) &&
      oper_ptr_o == $past(ld_oper_i) && $stable(opcode_o)));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retire_i && !clear_i && !load_i) |=>
      ($stable(instr_ptr_o) && $stable(oper_ptr_o) && $stable(opcode_o)));
endmodule

bind fp_last_ctx fp_last_ctx_chk u_chk (.*);

// File: tb/fp_last_ctx_test.sv
`timescale 1ns/1ps
module fp_last_ctx_test;
  localparam int PW = 48;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic retire, ctrl, mem_op, clear, load;
  logic [31:0] ioff, doff;
  logic [15:0] isel, dsel;
  logic [7:0]  b0, b1;
  logic [PW-1:0] ld_i, ld_d;
  logic [PW-1:0] ip, dp;
  logic [10:0] opc;
  logic [PW-1:0] e_ip, e_dp;
  logic [10:0] e_opc;
  bit dp_known;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fp_last_ctx uut (
    .clk_i(clk), .rst_ni(rst_ni), .retire_i(retire), .ctrl_i(ctrl),
    .mem_op_i(mem_op), .instr_off_i(ioff), .instr_sel_i(isel),
    .oper_off_i(doff), .oper_sel_i(dsel), .op_b0_i(b0), .op_b1_i(b1),
    .clear_i(clear), .load_i(load), .ld_instr_i(ld_i), .ld_oper_i(ld_d),
    .instr_ptr_o(ip), .oper_ptr_o(dp), .opcode_o(opc)
  );

  function automatic logic [10:0] pack_op(logic [7:0] a, logic [7:0] b);
    return {a[2:0], b};
  endfunction

  task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    retire = 0; ctrl = 0; mem_op = 0; clear = 0; load = 0;
  endtask

  // model update mirrors requirements R2..R8
  task automatic step(string req);
    if (clear) begin e_ip = '0; e_dp = '0; e_opc = '0; dp_known = 1; end
    else if (load) begin e_ip = ld_i; e_dp = ld_d; dp_known = 1; end
    else if (retire && !ctrl) begin
      e_ip = {isel, ioff}; e_opc = pack_op(b0, b1);
      if (mem_op) begin e_dp = {dsel, doff}; dp_known = 1; end
      else dp_known = 0;
    end
    @(posedge clk); #1;
    chk({req, " ip"}, ip, e_ip);
    chk({req, " opc"}, {37'd0, opc}, {37'd0, e_opc});
    if (dp_known) chk({req, " dp"}, dp, e_dp);
    idle();
  endtask

  task automatic rnd_data();
    ioff = $urandom; isel = 16'($urandom); doff = $urandom; dsel = 16'($urandom);
    b0 = 8'($urandom); b1 = 8'($urandom);
    ld_i = {16'($urandom), 32'($urandom)}; ld_d = {16'($urandom), 32'($urandom)};
  endtask

  initial begin
    #40000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c7a));
    idle(); rnd_data();
    e_ip = '0; e_dp = '0; e_opc = '0; dp_known = 1;
    #9; rst_ni = 1; #1;
    chk("R1 ip", ip, '0); chk("R1 dp", dp, '0); chk("R1 opc", {37'd0, opc}, '0);
    @(negedge clk);

    // R2 R3 R4 directed: field seams
    ioff = 32'h8000_0001; isel = 16'hFFFF; doff = 32'hFFFF_FFFF; dsel = 16'h8001;
    b0 = 8'hDD; b1 = 8'hE9; retire = 1; mem_op = 1; step("R2/R3/R4 directed");
    chk("R3 pack", {37'd0, opc}, {37'd0, 11'h5E9});
    // R3 upper bits of byte0 dropped
    b0 = 8'h05; b1 = 8'h00; retire = 1; step("R3 upper bits");
    // R4 no memory operand: dp not checked
    rnd_data(); retire = 1; mem_op = 0; step("R4 no mem");
    // R5 control retire holds
    rnd_data(); retire = 1; mem_op = 1; step("R2 seed");
    rnd_data(); retire = 1; ctrl = 1; mem_op = 1; step("R5 ctrl hold");
    // R6 clear vs retire
    rnd_data(); retire = 1; mem_op = 1; clear = 1; step("R6 clear prio");
    // R7 load then load vs retire, clear vs load
    rnd_data(); load = 1; retire = 1; mem_op = 1; step("R7 load prio");
    rnd_data(); load = 1; clear = 1; step("R7 clear over load");
    rnd_data(); load = 1; step("R7 load keeps opc");
    // R8 idle
    rnd_data(); step("R8 idle");

    for (int i = 0; i < 2000; i++) begin
      rnd_data();
      retire = 1'($urandom); ctrl = ($urandom % 4) == 0; mem_op = 1'($urandom);
      clear = ($urandom % 16) == 0; load = ($urandom % 12) == 0;
      step("R2-mix random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule